// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits on the host side of a system management bus. It takes one requested transaction, such as a quick command, a byte or word access to a device register, a process call or a block transfer. It then issues the ordered list of byte-level primitives for that transaction to a downstream bit-level engine. That engine drives the wires. This block decides only what goes on the bus and in which order: start conditions, address bytes, written bytes, reads with the host's acknowledge choice, and the closing stop.

The caller presents the transaction type, a 7-bit target address, a command byte, a block length and up to 32 write bytes as a flat vector. The vector is captured into an internal buffer when the request is accepted. Commands leave on a valid/ready port. The engine returns exactly one response for every command it accepts. The response carries an acknowledge flag, which matters for address and write commands, and a data byte, which matters for reads. Read bytes collect in a result vector, indexed from byte 0. The sequencer reports the number of bytes stored, a one-cycle completion pulse, and two error flags.

A target that refuses an address or a written byte ends the transaction early with a stop. For block reads the device supplies the length. A length the host cannot accept is refused before any data is read.

Top module: `smb_seq`

## Requirements
- R1: Type codes are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read. Command codes are 0 start, 1 repeated start, 2 address, 3 write, 4 read-and-ACK, 5 read-and-NACK, 6 stop, 7 read-and-hold, 8 give ACK, 9 give NACK. Every transaction begins with a start followed by an address command whose byte is {address, direction}, with read=1 and write=0.
- R2: A quick transaction issues start, address carrying req_qbit as the direction bit, then stop. No data command is issued and rd_count stays 0.
- R3: Send byte issues start, address(write), write(byte 0 of req_wdata), stop. Receive byte issues start, address(read), read-and-NACK, stop, and stores the byte at rd_data[7:0].
- R4: Write byte and write word issue start, address(write), write(command), then the data bytes, then stop. A word is sent low byte first, using req_wdata[7:0] and then [15:8].
- R5: Read byte and read word issue start, address(write), write(command), repeated start, address(read), then the reads, then stop. Every read except the last uses read-and-ACK and the last uses read-and-NACK. The first byte read lands in rd_data[7:0] (the low byte of a word).
- R6: A process call writes the command and two data bytes, low byte first. It then issues a repeated start and address(read), reads two bytes (ACK then NACK) and ends with a stop, all in one transaction.
- R7: Block write sends the count byte right after the command, then that many bytes from req_wdata, low byte first. The count is req_len limited to 32.
- R8: Block read, after the repeated start and address(read), issues read-and-hold for the count byte. It then gives ACK and reads exactly that many bytes, the last one NACKed. rd_count ends equal to the count.
- R9: A block read count of 0 or above 32 gets give NACK, then stop. cnt_err is set, nack_err stays clear and rd_count is 0.
- R10: When an address or write command receives a response with rsp_ack=0, the next command is stop. nack_err is set and no further command of that transaction is issued.
- R11: req_ready is high only while idle, and a request presented while busy is ignored. done is a one-cycle pulse in the cycle after the stop's response arrives. The error flags, rd_data and rd_count hold until the next accepted request.
- R12: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op and cmd_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_type | input | 4 | Transaction type code (R1) |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_len | input | 6 | Block write length |
| req_qbit | input | 1 | Direction bit for quick |
| req_wdata | input | 256 | Write bytes, byte i at [8i+7:8i] |
| cmd_valid | output | 1 | Primitive command valid |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 4 | Primitive code (R1) |
| cmd_data | output | 8 | Address or data byte for the primitive |
| rsp_valid | input | 1 | Engine response for the last command |
| rsp_ack | input | 1 | Target acknowledged (address/write) |
| rsp_data | input | 8 | Byte received (reads) |
| rd_data | output | 256 | Read bytes, byte i at [8i+7:8i] |
| rd_count | output | 6 | Bytes stored in rd_data |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Target refused an address or byte |
| cnt_err | output | 1 | Block read count out of range |

## Verification
A wrong phase or type decode appears at the command port on the very next primitive, as an extra, missing or reordered command. The bench catches this when it compares each accepted command in order against a stream built from the requirements. A bad byte index or count register appears only at completion, as a mismatch in rd_data, in rd_count or in the count byte of a block write. A lost error latch appears in the flags sampled with the done pulse. A broken truncation after a refusal appears at once, as a command other than stop.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [3:0] {
        TX_QUICK  = 4'd0,
        TX_SEND   = 4'd1,
        TX_RECV   = 4'd2,
        TX_WRBYTE = 4'd3,
        TX_RDBYTE = 4'd4,
        TX_WRWORD = 4'd5,
        TX_RDWORD = 4'd6,
        TX_PCALL  = 4'd7,
        TX_BWRITE = 4'd8,
        TX_BREAD  = 4'd9
    } txn_e;

    typedef enum logic [3:0] {
        OP_START     = 4'd0,
        OP_RSTART    = 4'd1,
        OP_ADDR      = 4'd2,
        OP_WRITE     = 4'd3,
        OP_RD_ACK    = 4'd4,
        OP_RD_NACK   = 4'd5,
        OP_STOP      = 4'd6,
        OP_RD_HOLD   = 4'd7,
        OP_GIVE_ACK  = 4'd8,
        OP_GIVE_NACK = 4'd9
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_ADDR1, PH_CMD, PH_WDATA, PH_RSTART,
        PH_ADDR2, PH_RCNT, PH_CACK, PH_RDATA, PH_STOP
    } phase_e;

endpackage

// File: rtl/smb_seq_wbuf.sv
module smb_seq_wbuf #(
    parameter int MAXB = 32,
    parameter int IW   = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MAXB*8-1:0] din,
    input  logic [IW-1:0]     idx,
    output logic [7:0]        byte_o
);
    logic [7:0] mem [MAXB];

    for (genvar g = 0; g < MAXB; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mem[g] <= 8'h00;
            else if (load) mem[g] <= din[g*8 +: 8];
        end
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < MAXB; i++) begin
            if (idx == IW'(i)) byte_o = mem[i];
        end
    end
endmodule

// File: rtl/smb_seq_rbuf.sv
module smb_seq_rbuf #(
    parameter int MAXB = 32,
    parameter int IW   = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [7:0]        din,
    output logic [MAXB*8-1:0] dout
);
    for (genvar g = 0; g < MAXB; g++) begin : g_byte
        logic [7:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       r_q <= 8'h00;
            else if (clr)                     r_q <= 8'h00;
            else if (we && idx == IW'(g))     r_q <= din;
        end
        assign dout[g*8 +: 8] = r_q;
    end
endmodule

// File: rtl/smb_seq_ctl.sv
module smb_seq_ctl
    import smb_seq_pkg::*;
#(
    parameter int MAXB = 32,
    parameter int IW   = $clog2(MAXB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_type,
    input  logic [6:0]    req_addr,
    input  logic [7:0]    req_cmd,
    input  logic [IW-1:0] req_len,
    input  logic          req_qbit,
    output logic          wbuf_load,
    output logic [IW-1:0] wbuf_idx,
    input  logic [7:0]    wbuf_byte,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [3:0]    cmd_op,
    output logic [7:0]    cmd_data,
    input  logic          rsp_valid,
    input  logic          rsp_ack,
    input  logic [7:0]    rsp_data,
    output logic          rbuf_clr,
    output logic          rbuf_we,
    output logic [IW-1:0] rbuf_idx,
    output logic [IW-1:0] rd_count,
    output logic          done,
    output logic          nack_err,
    output logic          cnt_err
);
    localparam logic [IW:0]   ONE_X = 1;
    localparam logic [IW-1:0] ONE_I = 1;
    localparam logic [IW-1:0] MAX_I = IW'(MAXB);
    localparam logic [7:0]    MAX_8 = 8'(MAXB);

    typedef struct packed {
        phase_e        ph;
        logic          busy_w;
        txn_e          ty;
        logic [6:0]    addr;
        logic [7:0]    cmd;
        logic          qbit;
        logic [IW-1:0] blen;
        logic [IW:0]   nwr;
        logic [IW-1:0] nrd;
        logic [IW:0]   idx;
        logic [7:0]    cnt8;
        logic [IW-1:0] rcnt;
        logic          done;
        logic          nack;
        logic          cerr;
    } st_t;

    st_t           q, d;
    op_e           op;
    logic [7:0]    dat;
    logic          is_rs, bad_cnt, last_w, last_r;
    logic [IW-1:0] clamp;
    txn_e          rty;

    always_comb begin
        rty     = txn_e'(req_type);
        is_rs   = q.ty inside {TX_RDBYTE, TX_RDWORD, TX_PCALL, TX_BREAD};
        bad_cnt = (q.cnt8 == 8'd0) || (q.cnt8 > MAX_8);
        last_w  = (q.idx + ONE_X) == q.nwr;
        last_r  = (q.idx + ONE_X) == {1'b0, q.nrd};
        clamp   = (req_len > MAX_I) ? MAX_I : req_len;
        wbuf_idx = (q.ty == TX_BWRITE && q.idx != '0) ? IW'(q.idx - ONE_X) : q.idx[IW-1:0];

        op  = OP_STOP;
        dat = 8'h00;
        case (q.ph)
            PH_START:  op = OP_START;
            PH_ADDR1: begin
                op  = OP_ADDR;
                dat = {q.addr, (q.ty == TX_QUICK) ? q.qbit : (q.ty == TX_RECV)};
            end
            PH_CMD: begin
                op  = OP_WRITE;
                dat = q.cmd;
            end
            PH_WDATA: begin
                op  = OP_WRITE;
                dat = (q.ty == TX_BWRITE && q.idx == '0) ? 8'(q.blen) : wbuf_byte;
            end
            PH_RSTART: op = OP_RSTART;
            PH_ADDR2: begin
                op  = OP_ADDR;
                dat = {q.addr, 1'b1};
            end
            PH_RCNT:   op = OP_RD_HOLD;
            PH_CACK:   op = bad_cnt ? OP_GIVE_NACK : OP_GIVE_ACK;
            PH_RDATA:  op = last_r ? OP_RD_NACK : OP_RD_ACK;
            default:   op = OP_STOP;
        endcase

        d         = q;
        d.done    = 1'b0;
        wbuf_load = 1'b0;
        rbuf_clr  = 1'b0;
        rbuf_we   = 1'b0;

        if (q.ph == PH_IDLE) begin
            if (req_valid) begin
                d.ph     = PH_START;
                d.busy_w = 1'b0;
                d.ty     = rty;
                d.addr   = req_addr;
                d.cmd    = req_cmd;
                d.qbit   = req_qbit;
                d.blen   = clamp;
                d.idx    = '0;
                d.rcnt   = '0;
                d.cnt8   = 8'h00;
                d.nack   = 1'b0;
                d.cerr   = 1'b0;
                d.nwr    = '0;
                d.nrd    = '0;
                case (rty)
                    TX_SEND, TX_WRBYTE: d.nwr = ONE_X;
                    TX_WRWORD:          d.nwr = ONE_X + ONE_X;
                    TX_PCALL: begin
                        d.nwr = ONE_X + ONE_X;
                        d.nrd = ONE_I + ONE_I;
                    end
                    TX_BWRITE:          d.nwr = {1'b0, clamp} + ONE_X;
                    TX_RECV, TX_RDBYTE: d.nrd = ONE_I;
                    TX_RDWORD:          d.nrd = ONE_I + ONE_I;
                    default: ;
                endcase
                wbuf_load = 1'b1;
                rbuf_clr  = 1'b1;
            end
        end else if (!q.busy_w) begin
            if (cmd_ready) d.busy_w = 1'b1;
        end else if (rsp_valid) begin
            d.busy_w = 1'b0;
            case (q.ph)
                PH_START: d.ph = PH_ADDR1;
                PH_ADDR1: begin
                    if (!rsp_ack) begin
                        d.nack = 1'b1;
                        d.ph   = PH_STOP;
                    end else begin
                        case (q.ty)
                            TX_QUICK: d.ph = PH_STOP;
                            TX_RECV:  d.ph = PH_RDATA;
                            TX_SEND:  d.ph = PH_WDATA;
                            default:  d.ph = PH_CMD;
                        endcase
                    end
                end
                PH_CMD: begin
                    if (!rsp_ack) begin
                        d.nack = 1'b1;
                        d.ph   = PH_STOP;
                    end else if (q.nwr != '0) d.ph = PH_WDATA;
                    else if (is_rs)         d.ph = PH_RSTART;
                    else                    d.ph = PH_STOP;
                end
                PH_WDATA: begin
                    if (!rsp_ack) begin
                        d.nack = 1'b1;
                        d.ph   = PH_STOP;
                    end else if (last_w) begin
                        d.idx = '0;
                        d.ph  = is_rs ? PH_RSTART : PH_STOP;
                    end else begin
                        d.idx = q.idx + ONE_X;
                    end
                end
                PH_RSTART: d.ph = PH_ADDR2;
                PH_ADDR2: begin
                    if (!rsp_ack) begin
                        d.nack = 1'b1;
                        d.ph   = PH_STOP;
                    end else begin
                        d.ph = (q.ty == TX_BREAD) ? PH_RCNT : PH_RDATA;
                    end
                end
                PH_RCNT: begin
                    d.cnt8 = rsp_data;
                    d.ph   = PH_CACK;
                end
                PH_CACK: begin
                    if (bad_cnt) begin
                        d.cerr = 1'b1;
                        d.ph   = PH_STOP;
                    end else begin
                        d.nrd = q.cnt8[IW-1:0];
                        d.ph  = PH_RDATA;
                    end
                end
                PH_RDATA: begin
                    rbuf_we = 1'b1;
                    d.rcnt  = q.rcnt + ONE_I;
                    if (last_r) begin
                        d.idx = '0;
                        d.ph  = PH_STOP;
                    end else begin
                        d.idx = q.idx + ONE_X;
                    end
                end
                default: begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    assign req_ready = (q.ph == PH_IDLE);
    assign cmd_valid = (q.ph != PH_IDLE) && !q.busy_w;
    assign cmd_op    = op;
    assign cmd_data  = dat;
    assign rbuf_idx  = q.idx[IW-1:0];
    assign rd_count  = q.rcnt;
    assign done      = q.done;
    assign nack_err  = q.nack;
    assign cnt_err   = q.cerr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/smb_seq.sv
module smb_seq #(
    parameter int MAXB = 32,
    parameter int IW   = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_type,
    input  logic [6:0]        req_addr,
    input  logic [7:0]        req_cmd,
    input  logic [IW-1:0]     req_len,
    input  logic              req_qbit,
    input  logic [MAXB*8-1:0] req_wdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [3:0]        cmd_op,
    output logic [7:0]        cmd_data,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [7:0]        rsp_data,
    output logic [MAXB*8-1:0] rd_data,
    output logic [IW-1:0]     rd_count,
    output logic              done,
    output logic              nack_err,
    output logic              cnt_err
);
    logic          wbuf_load, rbuf_clr, rbuf_we;
    logic [IW-1:0] wbuf_idx, rbuf_idx;
    logic [7:0]    wbuf_byte;

    smb_seq_wbuf #(.MAXB(MAXB), .IW(IW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .load(wbuf_load), .din(req_wdata),
        .idx(wbuf_idx), .byte_o(wbuf_byte)
    );

    smb_seq_rbuf #(.MAXB(MAXB), .IW(IW)) u_rbuf (
        .clk(clk), .rst_n(rst_n), .clr(rbuf_clr), .we(rbuf_we),
        .idx(rbuf_idx), .din(rsp_data), .dout(rd_data)
    );

    smb_seq_ctl #(.MAXB(MAXB), .IW(IW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len), .req_qbit(req_qbit),
        .wbuf_load(wbuf_load), .wbuf_idx(wbuf_idx), .wbuf_byte(wbuf_byte),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .rbuf_clr(rbuf_clr), .rbuf_we(rbuf_we), .rbuf_idx(rbuf_idx),
        .rd_count(rd_count), .done(done), .nack_err(nack_err), .cnt_err(cnt_err)
    );
endmodule

// File: rtl/smb_seq_chk.sv
module smb_seq_chk
    import smb_seq_pkg::*;
#(
    parameter int MAXB = 32,
    parameter int IW   = $clog2(MAXB + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [3:0]    cmd_op,
    input logic [7:0]    cmd_data,
    input logic          rsp_valid,
    input logic          rsp_ack,
    input logic [IW-1:0] rd_count,
    input logic          done,
    input logic          nack_err,
    input logic          cnt_err
);
    logic [3:0] last_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_op <= OP_STOP;
        else if (cmd_valid && cmd_ready) last_op <= cmd_op;
    end

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_START && cmd_valid) |-> cmd_op == OP_ADDR); // R1

    AST_RSTART_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_RSTART && cmd_valid) |-> (cmd_op == OP_ADDR && cmd_data[0])); // R5

    AST_RDCOUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count <= IW'(MAXB)); // R8

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(nack_err && cnt_err)); // R9

    AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack && (last_op == OP_ADDR || last_op == OP_WRITE))
        |=> (cmd_valid && cmd_op == OP_STOP)); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid)); // R11

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data))); // R12
endmodule

bind smb_seq smb_seq_chk #(.MAXB(MAXB), .IW(IW)) u_chk (.*);

// File: tb/smb_seq_bench.sv
module smb_seq_bench;
    localparam int MAXB = 32;
    localparam int IW   = 6;

    localparam int T_QUICK = 0, T_SEND = 1, T_RECV = 2, T_WRB = 3, T_RDB = 4,
                   T_WRW = 5, T_RDW = 6, T_PC = 7, T_BW = 8, T_BR = 9;
    localparam logic [3:0] C_S = 0, C_RS = 1, C_A = 2, C_W = 3, C_RA = 4, C_RN = 5,
                           C_P = 6, C_RH = 7, C_GA = 8, C_GN = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [3:0] req_type = '0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_cmd = '0;
    logic [IW-1:0] req_len = '0;
    logic req_qbit = 1'b0;
    logic [MAXB*8-1:0] req_wdata = '0;
    logic cmd_valid, cmd_ready = 1'b0;
    logic [3:0] cmd_op;
    logic [7:0] cmd_data;
    logic rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_data = '0;
    logic [MAXB*8-1:0] rd_data;
    logic [IW-1:0] rd_count;
    logic done, nack_err, cnt_err;

    smb_seq #(.MAXB(MAXB), .IW(IW)) u_smb_seq (.*);

    always #10 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit finished = 0;
    string tag = "";

    logic [11:0] exp_q[$];
    logic [7:0]  rd_src[64];
    logic [7:0]  wsrc[MAXB];
    int nack_at = -1, stall_set = 0, stall_cnt = 0, cmd_n = 0, rd_i = 0;
    logic [7:0] cnt_byte = 0;
    bit pend = 0, pend_ack = 0;
    logic [7:0] pend_data = 0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // engine model and command monitor (scoreboard pop side)
    always @(negedge clk) begin
        if (rst_n) begin
            rsp_valid = 1'b0;
            cmd_ready = 1'b0;
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_ack   = pend_ack;
                rsp_data  = pend_data;
                pend      = 1'b0;
            end else if (cmd_valid) begin
                if (stall_cnt > 0) stall_cnt--;
                else begin
                    cmd_ready = 1'b1;
                    stall_cnt = stall_set;
                    if (cmd_op == C_S) begin cmd_n = 0; rd_i = 0; end
                    if (exp_q.size() == 0)
                        check(1'b0, {tag, " unexpected command"}, {20'd0, cmd_op, cmd_data}, 32'hFFF);
                    else begin
                        logic [11:0] e;
                        e = exp_q.pop_front();
                        check({cmd_op, cmd_data} == e, {tag, " command order"}, {20'd0, cmd_op, cmd_data}, {20'd0, e});
                    end
                    pend_ack  = 1'b1;
                    pend_data = 8'h00;
                    case (cmd_op)
                        C_A, C_W: pend_ack = (cmd_n != nack_at);
                        C_RA, C_RN: begin pend_data = rd_src[rd_i]; rd_i++; end
                        C_RH: pend_data = cnt_byte;
                        default: ;
                    endcase
                    cmd_n++;
                    pend = 1'b1;
                end
            end
        end
    end

    task automatic run(input int ty, input logic [6:0] a, input logic [7:0] c, input int len,
                       input bit qb, input int nk, input logic [7:0] cb, input int st,
                       input logic [7:0] seed, input bit poke, input string t);
        logic [11:0] full[$];
        logic [MAXB*8-1:0] exp_rd;
        int nrd, lim, k;
        bit exp_nack, exp_cerr;
        tag = t;
        for (int i = 0; i < MAXB; i++) wsrc[i] = 8'(seed + 8'(i * 5));
        for (int i = 0; i < 64; i++) rd_src[i] = 8'(seed ^ 8'(i * 3 + 1));
        full.push_back({C_S, 8'h00});
        full.push_back({C_A, a, (ty == T_QUICK) ? qb : (ty == T_RECV)});
        case (ty)
            T_SEND: full.push_back({C_W, wsrc[0]});
            T_RECV: full.push_back({C_RN, 8'h00});
            T_WRB: begin full.push_back({C_W, c}); full.push_back({C_W, wsrc[0]}); end
            T_WRW: begin full.push_back({C_W, c}); full.push_back({C_W, wsrc[0]}); full.push_back({C_W, wsrc[1]}); end
            T_RDB, T_RDW, T_PC, T_BR: begin
                full.push_back({C_W, c});
                if (ty == T_PC) begin full.push_back({C_W, wsrc[0]}); full.push_back({C_W, wsrc[1]}); end
                full.push_back({C_RS, 8'h00});
                full.push_back({C_A, a, 1'b1});
                if (ty == T_RDB) full.push_back({C_RN, 8'h00});
                else if (ty == T_BR) begin
                    full.push_back({C_RH, 8'h00});
                    if (cb == 0 || cb > MAXB) full.push_back({C_GN, 8'h00});
                    else begin
                        full.push_back({C_GA, 8'h00});
                        for (int i = 0; i < int'(cb) - 1; i++) full.push_back({C_RA, 8'h00});
                        full.push_back({C_RN, 8'h00});
                    end
                end else begin full.push_back({C_RA, 8'h00}); full.push_back({C_RN, 8'h00}); end
            end
            T_BW: begin
                lim = (len > MAXB) ? MAXB : len;
                full.push_back({C_W, c});
                full.push_back({C_W, 8'(lim)});
                for (int i = 0; i < lim; i++) full.push_back({C_W, wsrc[i]});
            end
            default: ;
        endcase
        full.push_back({C_P, 8'h00});
        exp_nack = (nk >= 0 && nk < full.size());
        exp_cerr = !exp_nack && ty == T_BR && (cb == 0 || cb > MAXB);
        exp_q.delete();
        nrd = 0;
        for (int i = 0; i < full.size(); i++) begin
            if (exp_nack && i > nk) break;
            exp_q.push_back(full[i]);
            if (full[i][11:8] == C_RA || full[i][11:8] == C_RN) nrd++;
        end
        if (exp_nack) exp_q.push_back({C_P, 8'h00});
        exp_rd = '0;
        for (int i = 0; i < nrd; i++) exp_rd[i*8 +: 8] = rd_src[i];
        nack_at = nk; stall_set = st; cnt_byte = cb;

        @(negedge clk);
        req_valid = 1'b1; req_type = 4'(ty); req_addr = a; req_cmd = c;
        req_len = IW'(len); req_qbit = qb;
        for (int i = 0; i < MAXB; i++) req_wdata[i*8 +: 8] = wsrc[i];
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_type = 4'(T_QUICK); req_qbit = 1'b1;
            @(negedge clk);
            check(req_ready == 1'b0, {t, " R11 ready low while busy"}, {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        k = 0;
        while (!done && k < 4000) begin @(negedge clk); k++; end
        check(done == 1'b1, {t, " R11 done reached"}, {31'd0, done}, 32'd1);
        check(exp_q.size() == 0, {t, " all commands issued"}, exp_q.size(), 32'd0);
        check(nack_err == exp_nack, {t, " R10 nack_err"}, {31'd0, nack_err}, {31'd0, exp_nack});
        check(cnt_err == exp_cerr, {t, " R9 cnt_err"}, {31'd0, cnt_err}, {31'd0, exp_cerr});
        check(rd_count == IW'(nrd), {t, " R8 rd_count"}, {26'd0, rd_count}, nrd);
        check(rd_data == exp_rd, {t, " R5 rd_data"}, rd_data[31:0], exp_rd[31:0]);
        @(negedge clk);
        check(done == 1'b0, {t, " R11 done single cycle"}, {31'd0, done}, 32'd0);
        check(req_ready == 1'b1, {t, " R11 idle after done"}, {31'd0, req_ready}, 32'd1);
        check(rd_count == IW'(nrd), {t, " R11 result held"}, {26'd0, rd_count}, nrd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 reset ready", {31'd0, req_ready}, 32'd1);
        check(cmd_valid == 1'b0, "R11 reset no command", {31'd0, cmd_valid}, 32'd0);
        check(done == 1'b0 && nack_err == 1'b0 && cnt_err == 1'b0, "R11 reset flags",
              {29'd0, done, nack_err, cnt_err}, 32'd0);
        check(rd_count == '0, "R11 reset rd_count", {26'd0, rd_count}, 32'd0);

        run(T_QUICK, 7'h21, 8'h00, 0, 1'b0, -1, 0, 0, 8'h10, 0, "R2 quick write");
        run(T_QUICK, 7'h5A, 8'h00, 0, 1'b1, -1, 0, 2, 8'h11, 0, "R2 R12 quick read stalled");
        run(T_SEND,  7'h33, 8'h00, 0, 1'b0, -1, 0, 0, 8'h40, 0, "R3 send byte");
        run(T_RECV,  7'h34, 8'h00, 0, 1'b0, -1, 0, 1, 8'h41, 0, "R3 receive byte");
        run(T_WRB,   7'h50, 8'hC3, 0, 1'b0, -1, 0, 0, 8'h60, 0, "R4 write byte");
        run(T_RDB,   7'h51, 8'h0E, 0, 1'b0, -1, 0, 0, 8'h70, 0, "R5 read byte");
        run(T_WRW,   7'h52, 8'h91, 0, 1'b0, -1, 0, 2, 8'h80, 0, "R4 write word");
        run(T_RDW,   7'h53, 8'h92, 0, 1'b0, -1, 0, 0, 8'h90, 0, "R5 read word");
        run(T_PC,    7'h54, 8'hA5, 0, 1'b0, -1, 0, 1, 8'hA0, 0, "R6 process call");
        run(T_BW,    7'h55, 8'h07, 3, 1'b0, -1, 0, 0, 8'hB0, 0, "R7 block write 3");
        run(T_BW,    7'h56, 8'h08, 32, 1'b0, -1, 0, 0, 8'hB7, 0, "R7 block write 32");
        run(T_BW,    7'h57, 8'h09, 40, 1'b0, -1, 0, 0, 8'hB9, 0, "R7 block write clamped");
        run(T_BR,    7'h58, 8'h0A, 0, 1'b0, -1, 8'd4, 0, 8'hC0, 0, "R8 block read 4");
        run(T_BR,    7'h59, 8'h0B, 0, 1'b0, -1, 8'd32, 1, 8'hC5, 0, "R8 block read 32");
        run(T_BR,    7'h5B, 8'h0C, 0, 1'b0, -1, 8'd1, 0, 8'hC9, 0, "R8 block read 1");
        run(T_BR,    7'h5C, 8'h0D, 0, 1'b0, -1, 8'd0, 0, 8'hD0, 0, "R9 block read count 0");
        run(T_BR,    7'h5D, 8'h0E, 0, 1'b0, -1, 8'd33, 0, 8'hD4, 0, "R9 block read count 33");
        run(T_WRB,   7'h60, 8'h11, 0, 1'b0, 1, 0, 0, 8'hE0, 0, "R10 nack on address");
        run(T_WRW,   7'h61, 8'h12, 0, 1'b0, 3, 0, 0, 8'hE4, 0, "R10 nack on low byte");
        run(T_RDW,   7'h62, 8'h13, 0, 1'b0, 4, 0, 0, 8'hE8, 0, "R10 nack on read address");
        run(T_BW,    7'h63, 8'h14, 5, 1'b0, 5, 0, 0, 8'hEC, 0, "R10 nack inside block");
        run(T_RDW,   7'h64, 8'h15, 0, 1'b0, -1, 0, 2, 8'hF0, 1, "R11 request while busy");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule